// File: doc/BRIEF.md
# FIFO DMA Request Handshake Controller

This block sits between an external DMA controller and the transmit and receive FIFOs of one serial channel. It raises a transmit request whenever the transmit FIFO has room and a programmed byte count is still outstanding. It raises a receive request whenever a whole block of received bytes is waiting, or a shorter block that closes a frame. The DMA controller answers with an active-low acknowledge. While that acknowledge is low, each write strobe goes straight to the transmit FIFO and each read strobe goes straight to the receive FIFO. Chip select and address are ignored during that time.

Software sets up a transmit transfer by writing a 16-bit byte count as two byte-wide registers: low byte first, then high byte. Writing the high byte loads the count. Transmit data then moves in blocks of `BLK_BYTES` (32 by default), and the last block carries whatever remains. Each request line drops on a fixed edge of the final strobe of its block. For transmit, that is the leading edge of the last write strobe. For receive, it is the trailing edge of the last read strobe. Every strobe is a level that can last one or more clock cycles, and it counts once, on its rising edge.

Top module: `dma_fifo_handshake`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `tx_req`, `rx_req`, `tx_fifo_we` and `rx_fifo_re` at that edge, and it also zeroes the byte count and both beat counters.
- R2: A CPU write strobe with `bus_cs` high, `dma_ack_n` high and `bus_addr` = `ADDR_CNT_LO` (default 8'h10) latches the low count byte. The same kind of write to `ADDR_CNT_HI` (default 8'h11) loads the count {high, low} and restarts the block. `tx_req` stays low while the count is zero.
- R3: `tx_req` rises one edge after a cycle in which it is low, the count is non-zero and `tx_room` is high. Each acknowledged write strobe lowers the count by one, and the count saturates at zero.
- R4: A write is the last of its block when it is write number `BLK_BYTES` of the block, or when the count is one. `tx_req` goes low at the clock edge where that write strobe is first seen high.
- R5: After a transmit block ends, `tx_req` stays low for exactly one cycle. It then rises again if the count is still non-zero and `tx_room` is high. It stays low once the count reaches zero.
- R6: `rx_req` rises one edge after `rx_level` >= `BLK_BYTES`, giving a block of `BLK_BYTES` reads. It also rises when `rx_eof` is high and `rx_level` is non-zero, giving a block of `rx_level` reads. It stays low below one block when `rx_eof` is low.
- R7: `rx_req` stays high while the last read strobe of the block is high. It goes low at the first clock edge where that strobe is seen low again.
- R8: While `dma_ack_n` is low, `bus_cs` and `bus_addr` are ignored. The rising edge of a write strobe gives a one-cycle `tx_fifo_we` pulse, with `tx_fifo_wdata` = `bus_wdata`. The rising edge of a read strobe gives a one-cycle `rx_fifo_re` pulse. A strobe longer than one cycle still gives exactly one pulse.
- R9: While `dma_ack_n` is high, FIFO access needs `bus_cs` high and `bus_addr` = `ADDR_FIFO` (default 8'h00). A strobe with `bus_cs` low has no effect, and CPU FIFO writes leave the byte count unchanged.
- R10: If a write strobe and a read strobe rise in the same cycle while the acknowledge is active, only the write is serviced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cs | input | 1 | CPU chip select, active high |
| bus_addr | input | AW | CPU register address |
| bus_wdata | input | 8 | Write data bus |
| wr_stb | input | 1 | Write strobe level, active high |
| rd_stb | input | 1 | Read strobe level, active high |
| dma_ack_n | input | 1 | DMA acknowledge, active low |
| tx_room | input | 1 | Transmit FIFO can accept data |
| rx_level | input | LW | Bytes held in the receive FIFO |
| rx_eof | input | 1 | Receive FIFO holds the end of a frame |
| tx_req | output | 1 | Transmit DMA request |
| rx_req | output | 1 | Receive DMA request |
| tx_fifo_we | output | 1 | Transmit FIFO write pulse |
| tx_fifo_wdata | output | 8 | Data for the transmit FIFO |
| rx_fifo_re | output | 1 | Receive FIFO read pulse |

## Verification
The bench builds the block with `BLK_BYTES` = 4 and `FIFO_DEPTH` = 16, and keeps the 16-bit count. With these values a count of 10 crosses two full block boundaries and ends on a partial block within a few dozen cycles. The one-cycle gap between blocks and the final drop to silence both appear in one run. A receive level of 3 with the frame flag set exercises the short end-of-frame block.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;

  typedef struct packed {
    logic dma_wr;     // acknowledged write strobe, rising edge
    logic dma_rd;     // acknowledged read strobe, rising edge
    logic rd_end;     // trailing edge of any read strobe
    logic cnt_lo_wr;  // CPU write to low count byte
    logic cnt_hi_wr;  // CPU write to high count byte
  } bus_evt_t;

endpackage

// File: rtl/dma_bus_decode.sv
module dma_bus_decode
  import dma_hs_pkg::*;
#(
  parameter int AW = 8,
  parameter logic [AW-1:0] ADDR_FIFO   = 'h00,
  parameter logic [AW-1:0] ADDR_CNT_LO = 'h10,
  parameter logic [AW-1:0] ADDR_CNT_HI = 'h11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_cs,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  input  logic          wr_stb,
  input  logic          rd_stb,
  input  logic          dma_ack_n,
  output bus_evt_t      evt,
  output logic          tx_fifo_we,
  output logic [7:0]    tx_fifo_wdata,
  output logic          rx_fifo_re
);

  logic wr_q, rd_q;
  logic wr_rise, rd_rise, rd_fall;
  logic dma_on, cpu_sel, fifo_hit;
  logic fifo_wr, fifo_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      wr_q <= wr_stb;
      rd_q <= rd_stb;
    end
  end

  always_comb begin
    wr_rise  = wr_stb & ~wr_q;
    rd_rise  = rd_stb & ~rd_q;
    rd_fall  = ~rd_stb & rd_q;
    dma_on   = ~dma_ack_n;
    // acknowledge overrides chip select and address decode
    cpu_sel  = ~dma_on & bus_cs;
    fifo_hit = cpu_sel & (bus_addr == ADDR_FIFO);

    evt.dma_wr    = dma_on & wr_rise;
    evt.dma_rd    = dma_on & rd_rise & ~wr_rise;
    evt.rd_end    = rd_fall;
    evt.cnt_lo_wr = cpu_sel & wr_rise & (bus_addr == ADDR_CNT_LO);
    evt.cnt_hi_wr = cpu_sel & wr_rise & (bus_addr == ADDR_CNT_HI);

    fifo_wr = evt.dma_wr | (fifo_hit & wr_rise);
    fifo_rd = evt.dma_rd | (fifo_hit & rd_rise & ~wr_rise);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_fifo_we    <= 1'b0;
      tx_fifo_wdata <= '0;
      rx_fifo_re    <= 1'b0;
    end else begin
      tx_fifo_we <= fifo_wr;
      rx_fifo_re <= fifo_rd;
      if (fifo_wr) tx_fifo_wdata <= bus_wdata;
    end
  end

endmodule

// File: rtl/dma_tx_ctl.sv
module dma_tx_ctl
  import dma_hs_pkg::*;
#(
  parameter int BLK_BYTES = 32,
  parameter int CNT_W     = 16,
  localparam int BW       = $clog2(BLK_BYTES)
) (
  input  logic       clk,
  input  logic       rst,
  input  bus_evt_t   evt,
  input  logic [7:0] bus_wdata,
  input  logic       tx_room,
  output logic       tx_req
);

  logic [7:0]       cnt_lo;
  logic [CNT_W-1:0] tx_cnt;
  logic [BW-1:0]    tx_beat;
  logic             last_beat;
  logic             cnt_nz;

  always_comb begin
    cnt_nz    = (tx_cnt != '0);
    last_beat = (tx_beat == BW'(BLK_BYTES - 1)) || (tx_cnt == CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_lo  <= '0;
      tx_cnt  <= '0;
      tx_beat <= '0;
      tx_req  <= 1'b0;
    end else begin
      if (evt.cnt_lo_wr) cnt_lo <= bus_wdata;

      if (evt.cnt_hi_wr) begin
        tx_cnt  <= CNT_W'({bus_wdata, cnt_lo});
        tx_beat <= '0;
      end else if (evt.dma_wr) begin
        if (cnt_nz) tx_cnt <= tx_cnt - CNT_W'(1);
        tx_beat <= last_beat ? '0 : tx_beat + BW'(1);
      end

      if (tx_req) begin
        // drop at leading edge of the last write of the block
        if (evt.dma_wr && last_beat) tx_req <= 1'b0;
      end else if (cnt_nz && tx_room) begin
        tx_req <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dma_rx_ctl.sv
module dma_rx_ctl
  import dma_hs_pkg::*;
#(
  parameter int BLK_BYTES  = 32,
  parameter int FIFO_DEPTH = 64,
  localparam int BW        = $clog2(BLK_BYTES),
  localparam int LW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  bus_evt_t      evt,
  input  logic [LW-1:0] rx_level,
  input  logic          rx_eof,
  output logic          rx_req
);

  logic [BW:0] blk_len;
  logic [BW:0] rx_beat;
  logic        end_pend;
  logic        full_blk, short_blk;

  always_comb begin
    full_blk  = (rx_level >= LW'(BLK_BYTES));
    short_blk = rx_eof && (rx_level != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_req   <= 1'b0;
      blk_len  <= '0;
      rx_beat  <= '0;
      end_pend <= 1'b0;
    end else if (rx_req) begin
      if (end_pend) begin
        // drop after trailing edge of the last read strobe
        if (evt.rd_end) begin
          rx_req   <= 1'b0;
          end_pend <= 1'b0;
          rx_beat  <= '0;
        end
      end else if (evt.dma_rd) begin
        rx_beat <= rx_beat + (BW+1)'(1);
        if (rx_beat == blk_len - (BW+1)'(1)) end_pend <= 1'b1;
      end
    end else if (full_blk) begin
      rx_req  <= 1'b1;
      blk_len <= (BW+1)'(BLK_BYTES);
      rx_beat <= '0;
    end else if (short_blk) begin
      rx_req  <= 1'b1;
      blk_len <= rx_level[BW:0];
      rx_beat <= '0;
    end
  end

endmodule

// File: rtl/dma_fifo_handshake.sv
module dma_fifo_handshake
  import dma_hs_pkg::*;
#(
  parameter int BLK_BYTES  = 32,
  parameter int FIFO_DEPTH = 64,
  parameter int CNT_W      = 16,
  parameter int AW         = 8,
  parameter logic [AW-1:0] ADDR_FIFO   = 'h00,
  parameter logic [AW-1:0] ADDR_CNT_LO = 'h10,
  parameter logic [AW-1:0] ADDR_CNT_HI = 'h11,
  localparam int LW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_cs,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  input  logic          wr_stb,
  input  logic          rd_stb,
  input  logic          dma_ack_n,
  input  logic          tx_room,
  input  logic [LW-1:0] rx_level,
  input  logic          rx_eof,
  output logic          tx_req,
  output logic          rx_req,
  output logic          tx_fifo_we,
  output logic [7:0]    tx_fifo_wdata,
  output logic          rx_fifo_re
);

  bus_evt_t evt;

  dma_bus_decode #(
    .AW(AW), .ADDR_FIFO(ADDR_FIFO),
    .ADDR_CNT_LO(ADDR_CNT_LO), .ADDR_CNT_HI(ADDR_CNT_HI)
  ) u_dec (
    .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .dma_ack_n(dma_ack_n), .evt(evt), .tx_fifo_we(tx_fifo_we),
    .tx_fifo_wdata(tx_fifo_wdata), .rx_fifo_re(rx_fifo_re)
  );

  dma_tx_ctl #(.BLK_BYTES(BLK_BYTES), .CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst(rst), .evt(evt), .bus_wdata(bus_wdata),
    .tx_room(tx_room), .tx_req(tx_req)
  );

  dma_rx_ctl #(.BLK_BYTES(BLK_BYTES), .FIFO_DEPTH(FIFO_DEPTH)) u_rx (
    .clk(clk), .rst(rst), .evt(evt), .rx_level(rx_level),
    .rx_eof(rx_eof), .rx_req(rx_req)
  );

endmodule

// File: rtl/dma_hs_checker.sv
module dma_hs_checker (
  input logic clk,
  input logic rst,
  input logic dma_ack_n,
  input logic wr_stb,
  input logic rd_stb,
  input logic tx_room,
  input logic tx_req,
  input logic rx_req,
  input logic tx_fifo_we,
  input logic rx_fifo_re
);

  p_reset_clears_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!tx_req && !rx_req && !tx_fifo_we && !rx_fifo_re));

  p_tx_rise_needs_room_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_req) |-> $past(tx_room));

  p_tx_drop_leading_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(tx_req)) |->
      ($past(wr_stb) && !$past(wr_stb, 2) && !$past(dma_ack_n)));

  p_rx_drop_trailing_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(rx_req)) |-> (!$past(rd_stb) && $past(rd_stb, 2)));

  p_we_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    tx_fifo_we |=> !tx_fifo_we);

  p_re_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rx_fifo_re |=> !rx_fifo_re);

  p_one_direction_r10: assert property (@(posedge clk) disable iff (rst)
    !(tx_fifo_we && rx_fifo_re));

endmodule

bind dma_fifo_handshake dma_hs_checker u_chk (
  .clk(clk), .rst(rst), .dma_ack_n(dma_ack_n), .wr_stb(wr_stb),
  .rd_stb(rd_stb), .tx_room(tx_room), .tx_req(tx_req), .rx_req(rx_req),
  .tx_fifo_we(tx_fifo_we), .rx_fifo_re(rx_fifo_re)
);

// File: tb/sim_dma_fifo_handshake.sv
`timescale 1ns/1ps
module sim_dma_fifo_handshake;

  localparam int BLK   = 4;
  localparam int DEPTH = 16;
  localparam int LW    = $clog2(DEPTH + 1);
  localparam logic [7:0] A_FIFO = 8'h00, A_LO = 8'h10, A_HI = 8'h11;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_cs = 0, wr_stb = 0, rd_stb = 0, dma_ack_n = 1, tx_room = 0, rx_eof = 0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic [LW-1:0] rx_level = '0;
  logic tx_req, rx_req, tx_fifo_we, rx_fifo_re;
  logic [7:0] tx_fifo_wdata;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  dma_fifo_handshake #(.BLK_BYTES(BLK), .FIFO_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .dma_ack_n(dma_ack_n), .tx_room(tx_room), .rx_level(rx_level),
    .rx_eof(rx_eof), .tx_req(tx_req), .rx_req(rx_req),
    .tx_fifo_we(tx_fifo_we), .tx_fifo_wdata(tx_fifo_wdata),
    .rx_fifo_re(rx_fifo_re));

  task automatic chk(input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cpu_wr(input logic cs, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_cs = cs; bus_addr = a; bus_wdata = d; wr_stb = 1;
    @(negedge clk);
    wr_stb = 0; bus_cs = 0;
  endtask

  // acknowledged write held for two cycles; checks pulse, data and request
  task automatic dma_wr(input logic [7:0] d, input logic cs, input logic [7:0] a,
                        input int exp_req, input string rq);
    @(negedge clk);
    dma_ack_n = 0; bus_cs = cs; bus_addr = a; bus_wdata = d; wr_stb = 1;
    @(negedge clk);
    chk("R8", "tx_fifo_we on write", int'(tx_fifo_we), 1);
    chk("R8", "tx_fifo_wdata", int'(tx_fifo_wdata), int'(d));
    chk(rq, "tx_req after write edge", int'(tx_req), exp_req);
    @(negedge clk);
    chk("R8", "tx_fifo_we single pulse", int'(tx_fifo_we), 0);
    wr_stb = 0; bus_cs = 0; dma_ack_n = 1;
  endtask

  task automatic dma_rd(input logic last, input int nxt_level);
    @(negedge clk);
    dma_ack_n = 0; rd_stb = 1;
    @(negedge clk);
    chk("R8", "rx_fifo_re on read", int'(rx_fifo_re), 1);
    chk("R7", "rx_req held at read leading edge", int'(rx_req), 1);
    @(negedge clk);
    chk("R8", "rx_fifo_re single pulse", int'(rx_fifo_re), 0);
    chk("R7", "rx_req held while strobe high", int'(rx_req), 1);
    if (last) rx_level = LW'(nxt_level);
    rd_stb = 0; dma_ack_n = 1;
    @(negedge clk);
    chk("R7", "rx_req after trailing edge", int'(rx_req), last ? 0 : 1);
  endtask

  task automatic t_reset();
    chk("R1", "tx_req at reset", int'(tx_req), 0);
    chk("R1", "rx_req at reset", int'(rx_req), 0);
    chk("R1", "tx_fifo_we at reset", int'(tx_fifo_we), 0);
    chk("R1", "rx_fifo_re at reset", int'(rx_fifo_re), 0);
  endtask

  task automatic t_zero_count();
    tx_room = 1;
    cpu_wr(1, A_LO, 8'h00);
    cpu_wr(1, A_HI, 8'h00);
    idle(3);
    chk("R2", "tx_req with zero count", int'(tx_req), 0);
    cpu_wr(1, A_LO, 8'h05);
    cpu_wr(0, A_HI, 8'h00);  // chip select low: no load
    idle(3);
    chk("R9", "tx_req after write with cs low", int'(tx_req), 0);
  endtask

  task automatic t_tx_blocks();
    cpu_wr(1, A_LO, 8'd10);
    cpu_wr(1, A_HI, 8'd0);
    @(negedge clk);
    chk("R3", "tx_req after count load", int'(tx_req), 1);
    for (int i = 1; i <= 10; i++) begin
      dma_wr(8'(8'h20 + i), 0, 8'h00, (i == 4 || i == 8 || i == 10) ? 0 : 1, "R4");
      if (i == 4 || i == 8) chk("R5", "tx_req rearms after block", int'(tx_req), 1);
    end
    idle(3);
    chk("R5", "tx_req stays low at count zero", int'(tx_req), 0);
  endtask

  task automatic t_ack_override();
    cpu_wr(1, A_LO, 8'd3);
    cpu_wr(1, A_HI, 8'd0);
    @(negedge clk);
    chk("R3", "tx_req for count 3", int'(tx_req), 1);
    dma_wr(8'h05, 1, A_HI, 1, "R8");   // address and cs ignored
    dma_wr(8'h06, 1, A_LO, 1, "R8");
    dma_wr(8'h07, 0, 8'h00, 0, "R4");  // count reaches one: last
    idle(3);
    chk("R8", "no reload through register decode", int'(tx_req), 0);
  endtask

  task automatic t_cpu_fifo();
    @(negedge clk);
    bus_cs = 1; bus_addr = A_FIFO; bus_wdata = 8'h5A; wr_stb = 1;
    @(negedge clk);
    chk("R9", "cpu fifo write pulse", int'(tx_fifo_we), 1);
    chk("R9", "cpu fifo write data", int'(tx_fifo_wdata), 8'h5A);
    wr_stb = 0; bus_cs = 0;
    @(negedge clk);
    bus_cs = 0; bus_addr = A_FIFO; wr_stb = 1;
    @(negedge clk);
    chk("R9", "fifo write with cs low", int'(tx_fifo_we), 0);
    wr_stb = 0;
    @(negedge clk);
    bus_cs = 1; bus_addr = A_FIFO; rd_stb = 1;
    @(negedge clk);
    chk("R9", "cpu fifo read pulse", int'(rx_fifo_re), 1);
    rd_stb = 0; bus_cs = 0;
    idle(2);
    chk("R9", "cpu fifo writes leave count", int'(tx_req), 0);
  endtask

  task automatic t_rx_full();
    rx_level = LW'(BLK - 1);
    idle(3);
    chk("R6", "rx_req below block", int'(rx_req), 0);
    rx_level = LW'(BLK + 2);
    @(negedge clk);
    @(negedge clk);
    chk("R6", "rx_req at full block", int'(rx_req), 1);
    for (int i = 1; i <= BLK; i++) dma_rd(i == BLK, 0);
    idle(2);
    chk("R7", "rx_req stays low after drain", int'(rx_req), 0);
  endtask

  task automatic t_rx_eof();
    rx_level = LW'(3); rx_eof = 1;
    @(negedge clk);
    @(negedge clk);
    chk("R6", "rx_req on end of frame", int'(rx_req), 1);
    for (int i = 1; i <= 3; i++) dma_rd(i == 3, 0);
    rx_eof = 0;
    idle(2);
    chk("R6", "rx_req low after short block", int'(rx_req), 0);
  endtask

  task automatic t_both();
    @(negedge clk);
    dma_ack_n = 0; wr_stb = 1; rd_stb = 1; bus_wdata = 8'hC3;
    @(negedge clk);
    chk("R10", "write serviced", int'(tx_fifo_we), 1);
    chk("R10", "read not serviced", int'(rx_fifo_re), 0);
    wr_stb = 0; rd_stb = 0; dma_ack_n = 1;
    idle(2);
  endtask

  task automatic t_room_and_reset();
    tx_room = 0;
    cpu_wr(1, A_LO, 8'd5);
    cpu_wr(1, A_HI, 8'd0);
    idle(3);
    chk("R3", "tx_req without room", int'(tx_req), 0);
    tx_room = 1;
    @(negedge clk);
    chk("R3", "tx_req once room appears", int'(tx_req), 1);
    rx_level = LW'(BLK);
    idle(2);
    rst = 1;
    @(negedge clk);
    chk("R1", "tx_req cleared by reset", int'(tx_req), 0);
    chk("R1", "rx_req cleared by reset", int'(rx_req), 0);
    rx_level = '0;
    rst = 0;
    idle(3);
    chk("R1", "count zeroed by reset", int'(tx_req), 0);
  endtask

  initial begin
    idle(3);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_zero_count();
    t_tx_blocks();
    t_ack_override();
    t_cpu_fifo();
    t_rx_full();
    t_rx_eof();
    t_both();
    t_room_and_reset();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule